// File: doc/BRIEF.md
# Pixel Coupling Weight and Leader Cell Detector

This block scans a small image held in an external read-only memory and labels each pixel as a leader cell or not. For every pixel it visits the 8-connected neighbours one after another. For each neighbour it derives a coupling weight that shrinks as the two grey levels move apart. The weight is the largest grey level divided by one plus the absolute difference, truncated to an integer. The weights of all neighbours inside the image are added, and the pixel is a leader when that sum is strictly above a threshold supplied at run time.

A colour build reads three channels per pixel. It forms one weight per channel and keeps the smallest. Results go out through a write port, one write per pixel in raster order. Each write carries the pixel index, the weight sum and the leader bit. The division is either a bit-serial restoring divider or a single-cycle quotient lookup, chosen by a parameter.

Top module: `lw_leader_detect`

## Requirements
- R1: With IMAX = 2^PIX_W - 1, the weight between grey pixels a and b is floor(IMAX / (1 + |a - b|)). For example, 36 and 24 give 19, 127 and 36 give 2, and equal pixels give IMAX.
- R2: In a colour build (COLOR=1), channel c of a pixel sits at bits [c*PIX_W +: PIX_W]. The weight is computed per channel with the R1 formula, and the smallest of the three is used.
- R3: The neighbours are the eight pixels whose row and column each differ by at most one. Positions outside the image contribute nothing, so corners sum 3 terms, edges 5 and interior pixels 8.
- R4: res_sum_o is the exact sum of the neighbour weights, with no overflow up to 8*IMAX.
- R5: res_leader_o is 1 exactly when res_sum_o is strictly greater than the threshold.
- R6: The threshold is taken from thr_i in the cycle start_i is accepted. Changes to thr_i during a scan have no effect on that scan.
- R7: A scan writes each pixel exactly once, in raster order. res_addr_o runs from 0 to IMG_W*IMG_H-1, where index = row*IMG_W + col.
- R8: busy_o rises the cycle after start_i is accepted. done_o pulses for one cycle, the cycle after the last pixel's write. busy_o is low the cycle after done_o.
- R9: start_i pulses while busy_o is high are ignored. There is no extra write, no restart and no second done pulse.
- R10: During and right after reset, busy_o, done_o and res_we_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan when idle |
| thr_i | input | PIX_W+4 | Leader threshold |
| img_addr_o | output | clog2(IMG_W*IMG_H) | Pixel index presented to the image memory |
| img_data_i | input | PIX_W or 3*PIX_W | Pixel read combinationally at img_addr_o |
| res_we_o | output | 1 | Result write strobe |
| res_addr_o | output | clog2(IMG_W*IMG_H) | Pixel index of the result |
| res_sum_o | output | PIX_W+4 | Neighbour weight sum |
| res_leader_o | output | 1 | Leader flag |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
The corner cases targeted are these:
- **Full-scale differences.** These make the divisor 2^PIX_W. A divider or lookup that wraps the divisor would return IMAX instead of 0 on a 0/255 checkerboard.
- **Uniform images.** These give sums exactly at 765, 1275 and 2040. Thresholds one below and equal to 1275 expose a non-strict comparison. An adder that is too narrow would wrap at 2040.
- **Threshold changed mid-scan.** This catches a design that compares against thr_i live instead of a captured copy.
- **Repeated start pulses during a scan.** These catch a design that restarts and rewrites early pixels, or that emits two done pulses.
- **Colour images whose channels disagree.** These catch a design that takes the maximum, or only one channel, instead of the minimum.

// File: rtl/lw_pkg.sv
package lw_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CENTER,
      S_NEIGH,
      S_WAIT,
      S_WRITE,
      S_DONE
   } lw_state_t;

   // neighbour slot k in 0..8 walks a 3x3 window row by row; slot 4 is the centre
   function automatic int nb_dx(input int k);
      return (k % 3) - 1;
   endfunction

   function automatic int nb_dy(input int k);
      return (k / 3) - 1;
   endfunction

endpackage

// File: rtl/lw_recip_div.sv
module lw_recip_div #(
   parameter int PIX_W    = 8,
   parameter int DIV_ITER = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [PIX_W-1:0] diff_i,
   output logic             done_o,
   output logic [PIX_W-1:0] quot_o
);

   localparam int DIV_W = PIX_W + 1;
   localparam int CNT_W = (PIX_W > 1) ? $clog2(PIX_W) : 1;
   localparam logic [PIX_W-1:0] IMAX_P = {PIX_W{1'b1}};
   localparam logic [DIV_W-1:0] IMAX_D = {1'b0, IMAX_P};

   if (PIX_W < 2 || PIX_W > 16) begin : g_bad_width
      $error("lw_recip_div: PIX_W out of range");
   end

   // divisor held for the whole operation
   logic [DIV_W-1:0] dvs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dvs_q <= '0;
      else if (go_i)  dvs_q <= {1'b0, diff_i} + DIV_W'(1);
   end

   if (DIV_ITER != 0) begin : g_iter
      logic [DIV_W-1:0] rem_q;
      logic [PIX_W-1:0] qt_q;
      logic [CNT_W-1:0] cnt_q;
      logic             run_q, done_q;
      logic [DIV_W:0]   trial, trial_sub;
      logic             ge;

      assign trial     = {rem_q, qt_q[PIX_W-1]};
      assign ge        = trial >= {1'b0, dvs_q};
      assign trial_sub = trial - {1'b0, dvs_q};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q  <= '0;
            qt_q   <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
         end else if (go_i) begin
            rem_q  <= '0;
            qt_q   <= IMAX_P;
            cnt_q  <= '0;
            run_q  <= 1'b1;
            done_q <= 1'b0;
         end else if (run_q) begin
            rem_q <= ge ? trial_sub[DIV_W-1:0] : trial[DIV_W-1:0];
            qt_q  <= {qt_q[PIX_W-2:0], ge};
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(PIX_W - 1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end else begin
            done_q <= 1'b0;
         end
      end

      assign done_o = done_q;
      assign quot_o = qt_q;
   end else begin : g_lookup
      logic [PIX_W-1:0] qt_q;
      logic             done_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            qt_q   <= '0;
            done_q <= 1'b0;
         end else begin
            done_q <= go_i;
            if (go_i)
               qt_q <= (diff_i == IMAX_P) ? '0 : IMAX_P / (diff_i + PIX_W'(1));
         end
      end

      assign done_o = done_q;
      assign quot_o = qt_q;
   end

   // R1: quotient is the truncated IMAX/divisor
   a_r1_quot_exact: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (((2*DIV_W)'(quot_o) * (2*DIV_W)'(dvs_q)) <= (2*DIV_W)'(IMAX_D)) &&
                 (((2*DIV_W)'(quot_o) + (2*DIV_W)'(1)) * (2*DIV_W)'(dvs_q) > (2*DIV_W)'(IMAX_D)));

endmodule

// File: rtl/lw_leader_detect.sv
module lw_leader_detect
   import lw_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int IMG_W    = 5,
   parameter int IMG_H    = 5,
   parameter int COLOR    = 0,
   parameter int DIV_ITER = 1,
   localparam int NCH      = (COLOR != 0) ? 3 : 1,
   localparam int PIX_BITS = NCH * PIX_W,
   localparam int NPIX     = IMG_W * IMG_H,
   localparam int ADDR_W   = $clog2(NPIX),
   localparam int SUM_W    = PIX_W + 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [SUM_W-1:0]    thr_i,
   output logic [ADDR_W-1:0]   img_addr_o,
   input  logic [PIX_BITS-1:0] img_data_i,
   output logic                res_we_o,
   output logic [ADDR_W-1:0]   res_addr_o,
   output logic [SUM_W-1:0]    res_sum_o,
   output logic                res_leader_o,
   output logic                busy_o,
   output logic                done_o
);

   localparam int COL_W = $clog2(IMG_W);
   localparam int ROW_W = $clog2(IMG_H);
   localparam int IMAX  = (1 << PIX_W) - 1;

   if (IMG_W < 2 || IMG_H < 2 || NPIX > 4096) begin : g_bad_size
      $error("lw_leader_detect: image size out of range");
   end
   if (COLOR != 0 && COLOR != 1) begin : g_bad_color
      $error("lw_leader_detect: COLOR must be 0 or 1");
   end

   lw_state_t           state_q;
   logic [COL_W-1:0]    col_q;
   logic [ROW_W-1:0]    row_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [3:0]          k_q;
   logic [PIX_BITS-1:0] ctr_q;
   logic [SUM_W-1:0]    sum_q;
   logic [SUM_W-1:0]    thr_q;
   logic [ADDR_W-1:0]   wr_cnt_q;

   // neighbour position
   int                  nc, nr;
   logic                nb_ok;
   logic [ADDR_W-1:0]   nb_addr;

   always_comb begin
      nc      = int'(col_q) + nb_dx(int'(k_q));
      nr      = int'(row_q) + nb_dy(int'(k_q));
      nb_ok   = (k_q != 4'd4) && (nc >= 0) && (nc < IMG_W) && (nr >= 0) && (nr < IMG_H);
      nb_addr = nb_ok ? ADDR_W'(nr * IMG_W + nc) : addr_q;
   end

   assign img_addr_o = (state_q == S_CENTER) ? addr_q : nb_addr;

   // per-channel weight
   logic                div_go;
   logic [NCH-1:0]      ch_done;
   logic [PIX_W-1:0]    ch_w [NCH];
   logic [PIX_W-1:0]    w_min;

   assign div_go = (state_q == S_NEIGH) && nb_ok;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [PIX_W-1:0] pa, pb, pd;
      assign pa = ctr_q[c*PIX_W +: PIX_W];
      assign pb = img_data_i[c*PIX_W +: PIX_W];
      assign pd = (pa > pb) ? (pa - pb) : (pb - pa);

      lw_recip_div #(
         .PIX_W    (PIX_W),
         .DIV_ITER (DIV_ITER)
      ) u_div (
         .clk    (clk),
         .rst_n  (rst_n),
         .go_i   (div_go),
         .diff_i (pd),
         .done_o (ch_done[c]),
         .quot_o (ch_w[c])
      );
   end

   always_comb begin
      w_min = ch_w[0];
      for (int c = 1; c < NCH; c++)
         if (ch_w[c] < w_min) w_min = ch_w[c];
   end

   // scan sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         col_q   <= '0;
         row_q   <= '0;
         addr_q  <= '0;
         k_q     <= '0;
         ctr_q   <= '0;
         sum_q   <= '0;
         thr_q   <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (start_i) begin
               thr_q   <= thr_i;
               col_q   <= '0;
               row_q   <= '0;
               addr_q  <= '0;
               state_q <= S_CENTER;
            end
            S_CENTER: begin
               ctr_q   <= img_data_i;
               k_q     <= '0;
               sum_q   <= '0;
               state_q <= S_NEIGH;
            end
            S_NEIGH: begin
               if (nb_ok)            state_q <= S_WAIT;
               else if (k_q == 4'd8) state_q <= S_WRITE;
               else                  k_q     <= k_q + 4'd1;
            end
            S_WAIT: if (&ch_done) begin
               sum_q <= sum_q + SUM_W'(w_min);
               if (k_q == 4'd8) state_q <= S_WRITE;
               else begin
                  k_q     <= k_q + 4'd1;
                  state_q <= S_NEIGH;
               end
            end
            S_WRITE: begin
               if (int'(addr_q) == NPIX - 1) state_q <= S_DONE;
               else begin
                  addr_q  <= addr_q + ADDR_W'(1);
                  state_q <= S_CENTER;
                  if (int'(col_q) == IMG_W - 1) begin
                     col_q <= '0;
                     row_q <= row_q + ROW_W'(1);
                  end else begin
                     col_q <= col_q + COL_W'(1);
                  end
               end
            end
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign res_we_o     = (state_q == S_WRITE);
   assign res_addr_o   = addr_q;
   assign res_sum_o    = sum_q;
   assign res_leader_o = sum_q > thr_q;
   assign busy_o       = (state_q != S_IDLE);
   assign done_o       = (state_q == S_DONE);

   // independent write counter used by the ordering check
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            wr_cnt_q <= '0;
      else if (start_i && state_q == S_IDLE) wr_cnt_q <= '0;
      else if (res_we_o)                     wr_cnt_q <= wr_cnt_q + ADDR_W'(1);
   end

   // R4: sum never exceeds eight full weights
   a_r4_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
      res_we_o |-> (int'(res_sum_o) <= 8 * IMAX));

   // R3: every address presented to the image lies inside it
   a_r3_addr_in_image: assert property (@(posedge clk) disable iff (!rst_n)
      int'(img_addr_o) < NPIX);

   // R7: writes follow raster order
   a_r7_raster_order: assert property (@(posedge clk) disable iff (!rst_n)
      res_we_o |-> (res_addr_o == wr_cnt_q));

   // R8: done follows the last pixel's write
   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(res_we_o) && int'($past(res_addr_o)) == NPIX - 1));

   // R6, R9: captured threshold is frozen while busy
   a_r6_thr_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(thr_q));

   // R10: no write or done outside a scan
   a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!res_we_o && !done_o));

endmodule

// File: tb/lw_leader_detect_tb.sv
module lw_leader_detect_tb;

   localparam int N = 25;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [11:0] thr;

   always #4 clk = ~clk;

   logic [7:0]  rom_g [N];
   logic [23:0] rom_c [N];

   logic [4:0]  addr_g, addr_c, raddr_g, raddr_c;
   logic [7:0]  dat_g;
   logic [23:0] dat_c;
   logic        we_g, we_c, ld_g, ld_c, busy_g, busy_c, done_g, done_c;
   logic [11:0] sum_g, sum_c;

   assign dat_g = rom_g[addr_g];
   assign dat_c = rom_c[addr_c];

   lw_leader_detect #(.COLOR(0), .DIV_ITER(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .thr_i(thr),
      .img_addr_o(addr_g), .img_data_i(dat_g),
      .res_we_o(we_g), .res_addr_o(raddr_g), .res_sum_o(sum_g), .res_leader_o(ld_g),
      .busy_o(busy_g), .done_o(done_g));

   lw_leader_detect #(.COLOR(1), .DIV_ITER(0)) u_rgb (
      .clk(clk), .rst_n(rst_n), .start_i(start), .thr_i(thr),
      .img_addr_o(addr_c), .img_data_i(dat_c),
      .res_we_o(we_c), .res_addr_o(raddr_c), .res_sum_o(sum_c), .res_leader_o(ld_c),
      .busy_o(busy_c), .done_o(done_c));

   int checks = 0;
   int fails  = 0;
   int exp_g [N];
   int exp_c [N];
   int thr_run;
   int idx_g, idx_c, dn_g, dn_c;
   bit pend_g, pend_c;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int wgt(input int a, input int b);
      return 255 / (1 + ((a > b) ? a - b : b - a));
   endfunction

   task automatic build();
      for (int p = 0; p < N; p++) begin
         int r = p / 5;
         int c = p % 5;
         exp_g[p] = 0;
         exp_c[p] = 0;
         for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++) begin
               int rr = r + dr;
               int cc = c + dc;
               if ((dr != 0 || dc != 0) && rr >= 0 && rr < 5 && cc >= 0 && cc < 5) begin
                  int q = rr * 5 + cc;
                  int m = 1 << 30;
                  exp_g[p] += wgt(int'(rom_g[p]), int'(rom_g[q]));
                  for (int ch = 0; ch < 3; ch++) begin
                     int w = wgt(int'(rom_c[p][ch*8 +: 8]), int'(rom_c[q][ch*8 +: 8]));
                     if (w < m) m = w;
                  end
                  exp_c[p] += m;
               end
            end
      end
   endtask

   // reference comparison on every clock, grey instance
   always @(negedge clk) if (rst_n) begin
      if (pend_g) chk(!busy_g, "R8 grey busy low after done", int'(busy_g), 0);
      pend_g = done_g;
      if (we_g) begin
         chk(idx_g < N && int'(raddr_g) == idx_g, "R7 grey write index", int'(raddr_g), idx_g);
         if (idx_g < N) begin
            chk(int'(sum_g) == exp_g[idx_g], "R1 R3 R4 grey sum", int'(sum_g), exp_g[idx_g]);
            chk(ld_g == (exp_g[idx_g] > thr_run), "R5 R6 grey leader", int'(ld_g),
                int'(exp_g[idx_g] > thr_run));
         end
         idx_g++;
      end
      if (done_g) begin
         chk(idx_g == N, "R8 grey done after last write", idx_g, N);
         dn_g++;
      end
   end

   // reference comparison on every clock, colour instance
   always @(negedge clk) if (rst_n) begin
      if (pend_c) chk(!busy_c, "R8 rgb busy low after done", int'(busy_c), 0);
      pend_c = done_c;
      if (we_c) begin
         chk(idx_c < N && int'(raddr_c) == idx_c, "R7 rgb write index", int'(raddr_c), idx_c);
         if (idx_c < N) begin
            chk(int'(sum_c) == exp_c[idx_c], "R2 rgb min-channel sum", int'(sum_c), exp_c[idx_c]);
            chk(ld_c == (exp_c[idx_c] > thr_run), "R5 R6 rgb leader", int'(ld_c),
                int'(exp_c[idx_c] > thr_run));
         end
         idx_c++;
      end
      if (done_c) begin
         chk(idx_c == N, "R8 rgb done after last write", idx_c, N);
         dn_c++;
      end
   end

   // disturb: 0 none, 1 threshold change mid-scan, 2 start pulses mid-scan
   task automatic run_scan(input int t, input int disturb);
      @(negedge clk);
      thr     = 12'(t);
      thr_run = t;
      build();
      idx_g = 0; idx_c = 0; dn_g = 0; dn_c = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy_g && busy_c, "R8 busy after start", int'(busy_g & busy_c), 1);
      if (disturb == 1) begin
         repeat (20) @(negedge clk);
         thr = 12'd0;
      end else if (disturb == 2) begin
         repeat (30) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (120) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int i = 0; i < 20000 && !(dn_g > 0 && dn_c > 0); i++) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(dn_g == 1, "R8 R9 grey single done", dn_g, 1);
      chk(dn_c == 1, "R8 R9 rgb single done", dn_c, 1);
      chk(idx_g == N, "R7 R9 grey write count", idx_g, N);
      chk(idx_c == N, "R7 R9 rgb write count", idx_c, N);
   endtask

   task automatic load_doc();
      int v [N] = '{24, 36, 127, 24, 127, 127, 128, 126, 36, 24, 36, 26, 24,
                    24, 127, 135, 127, 36, 36, 24, 24, 24, 127, 36, 127};
      for (int p = 0; p < N; p++) begin
         rom_g[p] = 8'(v[p]);
         rom_c[p] = {8'(255 - v[p]), 8'((v[p] * 3) & 255), 8'(v[p])};
      end
   endtask

   initial begin
      #(8 * 190000);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      thr   = '0;
      idx_g = 0; idx_c = 0; dn_g = 0; dn_c = 0; thr_run = 0;
      pend_g = 1'b0; pend_c = 1'b0;
      load_doc();
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!busy_g && !busy_c, "R10 busy in reset", int'(busy_g | busy_c), 0);
      chk(!done_g && !done_c, "R10 done in reset", int'(done_g | done_c), 0);
      chk(!we_g && !we_c, "R10 write in reset", int'(we_g | we_c), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_g && !we_g && !done_g, "R10 quiet after reset", int'(busy_g | we_g | done_g), 0);

      // R1, R3, R5: mixed image
      run_scan(200, 0);
      run_scan(1000, 0);

      // R3, R4, R5: uniform image, corner 765, edge 1275, interior 2040
      for (int p = 0; p < N; p++) begin
         rom_g[p] = 8'd77;
         rom_c[p] = {8'd9, 8'd200, 8'd77};
      end
      run_scan(1275, 0);
      run_scan(1274, 0);

      // R1, R2: full-scale checkerboard, divisor 256 gives weight 0
      for (int p = 0; p < N; p++) begin
         rom_g[p] = (p % 2 == 0) ? 8'd255 : 8'd0;
         rom_c[p] = (p % 2 == 0) ? {8'd255, 8'd0, 8'd255} : {8'd0, 8'd0, 8'd0};
      end
      run_scan(1019, 0);

      // R6: threshold changed during scan
      load_doc();
      run_scan(500, 1);

      // R9: start pulses while busy
      run_scan(300, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule